// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block holds a small bank of performance counters that watch a memory controller. A set of single-cycle event strobes comes from the controller. Software configures and reads the counters through a simple register port: an address, a write enable, 32-bit write data and registered read data.

Counter 0 is the master. It counts clock cycles only. When it wraps, every counter in the bank stops and the interrupt line goes high. Each other counter picks one strobe bit through an event code in its control word. Such a counter stops when it wraps and sets its own overflow flag, but it raises no interrupt.

Each counter has a preload field. On enable it seeds the middle byte of the count so that overflow comes sooner. Software clears a counter by writing zero to its clear bit. An event counter re-arms that bit by itself on the next cycle. The cycle counter keeps the bit at zero until software writes a one.

Top module: `mc_evt_counter_bank`

## Requirements
- R1: After reset every control word reads 0x0000_0002, every count reads 0 and `irq` is low.
- R2: Control word n is at byte address 4*n and count n is at 0x20 + 4*n. Control bit 0 is the overflow flag (read-only), bit 1 is clear (active low), bit 2 is enable, bits 23:16 hold the preload value and bits 31:24 hold the event code. Writes to a count address are ignored.
- R3: Counter 0 adds one on every clock edge while it is enabled, its clear bit is 1 and it has not overflowed. It ignores its event-code field.
- R4: Counters 1 to 3 add one on each edge where `evt_strobe[code]` is high. Code 0, or a code of `EVT_W` or above, counts nothing. For example, code 0x37 counts only bit 55.
- R5: A control write that sets enable while the counter was disabled, with clear at 1, loads the preload byte into count bits PRE_LSB+7:PRE_LSB (16 by default). The other count bits are kept.
- R6: With enable at 0, a counter keeps its value, ignores strobes and still reads back.
- R7: Writing clear = 0 zeroes the count and the overflow flag. An event counter's clear bit reads 1 again one cycle later. The cycle counter's clear bit stays 0, and the counter does not count, until a 1 is written.
- R8: An event counter that increments from all ones wraps to 0, sets its overflow flag and holds until it is cleared. It does not raise `irq`.
- R9: When counter 0 wraps, it sets its overflow flag and raises `irq`. Strobes on the same edge are still counted. From the next edge on, all counters hold and strobes are dropped.
- R10: `irq` stays high until a write of clear = 0 to control word 0. After that the counters resume.
- R11: A control write to a counter takes priority over that counter's increment on the same edge.
- R12: `reg_rdata` is registered and shows the word at the address presented one edge earlier. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_strobe | input | EVT_W | Event strobes, one bit per event code |
| irq | output | 1 | Cycle-counter overflow interrupt |

## Verification
The cycle counter's wrap and an event counter's increment can fall on the same edge. The freeze must then start one edge later, so that event is still counted. To provoke this, counter 0 is preloaded close to wrapping in the very write where a strobe selected by counter 1 goes high and stays high. Counter 1 must then read exactly the number of edges from that write up to and including the wrap, 257 in the test setup. It must keep that value while the strobe stays high. The bench also sends a control write on the edge where the cycle counter would otherwise increment, and judges from the exact count that the write wins.

// File: rtl/mc_evt_counter_bank.sv
`timescale 1ns/1ps
module mc_evt_counter_bank #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int PRE_LSB = 16,
  parameter int EVT_W   = 64,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [EVT_W-1:0]  evt_strobe,
  output logic              irq
);
  localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int SEL_IW   = (EVT_W > 1) ? $clog2(EVT_W) : 1;
  localparam int CNT_BASE = 'h20;

  logic [NUM_CNT-1:0]       en_q, clr_q, ovf_q;
  logic [31:0]              ctrl_word [NUM_CNT];
  logic [CNT_W-1:0]         cnt_q [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                     unused_bits;

  wire aligned  = (reg_addr[1:0] == 2'b00);
  wire ctrl_sel = aligned && (reg_addr < ADDR_W'(4*NUM_CNT));
  wire cnt_sel  = aligned && (reg_addr >= ADDR_W'(CNT_BASE))
                          && (reg_addr < ADDR_W'(CNT_BASE + 4*NUM_CNT));
  wire [IDX_W-1:0] sel_idx = reg_addr[IDX_W+1:2];

  assign unused_bits = ^reg_wdata[15:3];
  assign irq = ovf_q[0];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic             en_r, clr_r, ovf_r, hit, run, wr_me;
    logic [7:0]       pre_r, sel_r;
    logic [CNT_W-1:0] cnt_r;
    logic [CNT_W:0]   inc;

    if (g == 0) begin : g_cyc
      assign hit = 1'b1;
    end else begin : g_evt
      assign hit = (sel_r != 8'd0) && (32'(sel_r) < 32'(EVT_W))
                   && evt_strobe[sel_r[SEL_IW-1:0]];
    end

    assign wr_me = reg_wr && ctrl_sel && (sel_idx == IDX_W'(g));
    assign run   = en_r & clr_r & ~ovf_r & ~ovf_q[0] & hit;
    assign inc   = {1'b0, cnt_r} + {{CNT_W{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        clr_r <= 1'b1;
        ovf_r <= 1'b0;
        pre_r <= 8'd0;
        sel_r <= 8'd0;
        cnt_r <= '0;
      end else if (wr_me) begin
        en_r  <= reg_wdata[2];
        clr_r <= reg_wdata[1];
        pre_r <= reg_wdata[23:16];
        sel_r <= reg_wdata[31:24];
        if (!reg_wdata[1]) begin
          cnt_r <= '0;
          ovf_r <= 1'b0;
        end else if (reg_wdata[2] && !en_r) begin
          cnt_r[PRE_LSB +: 8] <= reg_wdata[23:16];
        end
      end else begin
        if (g != 0 && !clr_r) clr_r <= 1'b1;
        if (run) begin
          cnt_r <= inc[CNT_W-1:0];
          if (inc[CNT_W]) ovf_r <= 1'b1;
        end
      end
    end

    assign en_q[g]      = en_r;
    assign clr_q[g]     = clr_r;
    assign ovf_q[g]     = ovf_r;
    assign cnt_q[g]     = cnt_r;
    assign ctrl_word[g] = {sel_r, pre_r, 13'd0, en_r, clr_r, ovf_r};
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        reg_rdata <= 32'd0;
    else if (ctrl_sel) reg_rdata <= ctrl_word[sel_idx];
    else if (cnt_sel)  reg_rdata <= 32'(cnt_q[sel_idx]);
    else               reg_rdata <= 32'd0;
  end
endmodule

// File: rtl/mc_evt_counter_bank_chk.sv
`timescale 1ns/1ps
module mc_evt_counter_bank_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [31:0]              reg_wdata,
  input logic                     irq,
  input logic [NUM_CNT-1:0]       en_q,
  input logic [NUM_CNT-1:0]       clr_q,
  input logic [NUM_CNT-1:0]       ovf_q,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  wire clr0_wr = reg_wr && (reg_addr == '0) && !reg_wdata[1];

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr0_wr) |=> irq);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q[0] && !reg_wr) |=> $stable(cnt_flat));

  // R3
  cycle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[0] && clr_q[0] && !ovf_q[0] && !reg_wr)
      |=> (cnt_flat[CNT_W-1:0] == $past(cnt_flat[CNT_W-1:0]) + 1'b1));

  for (genvar n = 1; n < NUM_CNT; n++) begin : g_evt_chk
    // R8
    evt_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[n] && !reg_wr) |=> $stable(cnt_flat[n*CNT_W +: CNT_W]));
    // R6
    disabled_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[n] && !reg_wr) |=> $stable(cnt_flat[n*CNT_W +: CNT_W]));
  end
endmodule

bind mc_evt_counter_bank mc_evt_counter_bank_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .en_q(en_q), .clr_q(clr_q),
  .ovf_q(ovf_q), .cnt_flat(cnt_flat)
);

// File: tb/mc_evt_counter_bank_tb.sv
`timescale 1ns/1ps
module mc_evt_counter_bank_tb;
  localparam int CNT_W = 16;
  localparam int EVT_W = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [EVT_W-1:0] evt_strobe = '0;
  logic        irq;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  mc_evt_counter_bank #(.NUM_CNT(4), .CNT_W(CNT_W), .PRE_LSB(8), .EVT_W(EVT_W), .ADDR_W(8))
  u_dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
         .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 v = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(8'(4*i), v);        check("R1 ctrl reset", v, 32'h2);
      rd(8'(8'h20 + 4*i), v); check("R1 count reset", v, 32'h0);
    end
    check("R1 irq reset", {31'd0, irq}, 32'h0);
    rd(8'h10, v); check("R12 unmapped read", v, 32'h0);
    rd(8'h21, v); check("R12 misaligned read", v, 32'h0);
  endtask

  task automatic t_cycle;
    logic [31:0] v;
    wr(8'h00, 32'h0400_0006);
    repeat (20) @(posedge clk);
    wr(8'h00, 32'h0400_0002);
    rd(8'h20, v); check("R3 R11 cycle count exact", v, 32'd20);
    rd(8'h00, v); check("R2 ctrl0 fields", v, 32'h0400_0002);
    repeat (10) @(posedge clk);
    rd(8'h20, v); check("R6 cycle counter frozen", v, 32'd20);
  endtask

  task automatic t_preload;
    logic [31:0] v;
    wr(8'h08, 32'h05AB_0006);
    rd(8'h28, v); check("R5 preload byte", v, 32'h0000_AB00);
    wr(8'h28, 32'h0000_1234);
    rd(8'h28, v); check("R2 count write ignored", v, 32'h0000_AB00);
    wr(8'h08, 32'h05AB_0002);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(8'h0C, 32'h3700_0006);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      evt_strobe = '0;
      if (i % 2 == 1) evt_strobe[55] = 1'b1;
      else begin evt_strobe[4] = 1'b1; evt_strobe[5] = 1'b1; end
    end
    @(negedge clk); evt_strobe = '0;
    rd(8'h2C, v); check("R4 code 0x37 counts bit 55", v, 32'd5);
    wr(8'h0C, 32'h0000_0006);
    @(negedge clk); evt_strobe = '1;
    repeat (5) @(negedge clk);
    evt_strobe = '0;
    rd(8'h2C, v); check("R4 code 0 counts nothing", v, 32'd5);
    wr(8'h0C, 32'h0000_0002);
  endtask

  task automatic t_evt_ovf;
    logic [31:0] v;
    wr(8'h08, 32'h0000_0000);
    rd(8'h28, v); check("R7 clear zeroes count", v, 32'h0);
    rd(8'h08, v); check("R7 event clear bit returns", v, 32'h2);
    wr(8'h08, 32'h05FF_0006);
    @(negedge clk); evt_strobe[5] = 1'b1;
    repeat (300) @(posedge clk);
    @(negedge clk); evt_strobe = '0;
    rd(8'h08, v); check("R8 event overflow flag", v, 32'h05FF_0007);
    rd(8'h28, v); check("R8 event counter held at wrap", v, 32'h0);
    check("R8 no irq from event counter", {31'd0, irq}, 32'h0);
    wr(8'h08, 32'h05FF_0004);
    repeat (2) @(posedge clk);
    @(negedge clk); evt_strobe[5] = 1'b1;
    repeat (3) @(negedge clk);
    evt_strobe = '0;
    rd(8'h28, v); check("R7 event counter resumes after clear", v, 32'd3);
    wr(8'h08, 32'h0000_0002);
  endtask

  task automatic t_halt;
    logic [31:0] v;
    wr(8'h04, 32'h0400_0006);
    wr(8'h00, 32'h0000_0000);
    @(negedge clk);
    reg_addr = 8'h00; reg_wdata = 32'h00FF_0006; reg_wr = 1'b1; evt_strobe[4] = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
    repeat (300) @(posedge clk);
    rd(8'h24, v); check("R9 wrap-cycle event counted", v, 32'd257);
    rd(8'h20, v); check("R9 cycle counter wrapped", v, 32'h0);
    rd(8'h00, v); check("R9 cycle overflow flag", v, 32'h00FF_0007);
    check("R9 irq raised", {31'd0, irq}, 32'h1);
    repeat (20) @(posedge clk);
    rd(8'h24, v); check("R9 events dropped while halted", v, 32'd257);
    check("R10 irq held", {31'd0, irq}, 32'h1);
  endtask

  task automatic t_resume;
    logic [31:0] v, w;
    wr(8'h00, 32'h0000_0004);
    check("R10 irq cleared", {31'd0, irq}, 32'h0);
    rd(8'h00, v); check("R7 cycle clear bit stays 0", v, 32'h0000_0004);
    repeat (10) @(posedge clk);
    rd(8'h20, v); check("R7 cycle counter idle until clear=1", v, 32'h0);
    rd(8'h24, w); check("R10 event counter resumed", {31'd0, w > 32'd257}, 32'h1);
    wr(8'h00, 32'h0000_0006);
    repeat (5) @(posedge clk);
    rd(8'h20, v); check("R10 cycle counter resumed", {31'd0, v > 32'd0}, 32'h1);
    evt_strobe = '0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_cycle;
    t_preload;
    t_select;
    t_evt_ovf;
    t_halt;
    t_resume;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule